// File: doc/BRIEF.md
# DDR Command Decoder and Bank-State Tracker

This block watches the control pins of a DDR SDRAM command bus from the controller side. On every rising clock edge it samples clock enable, chip select, the three command strobes, the two bank-select bits and the address bus. It decodes them into a command and checks that command against a model of the four banks and of the power mode. Each bank is idle, open with a latched row, or closing during a precharge window of `TRP_CYC` cycles. The power mode is awake, precharge power-down, active power-down or self refresh.

All outputs are registered and change at the edge that samples the command. `cmd_o` reports the command the block acted on. `illegal_o` marks a command that arrived in a state that forbids it; such a command is dropped without side effects. Typical uses are protocol checking beside a memory controller, or a front end for a memory model.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: After reset, `cmd_o` is NOP (1), `illegal_o` is 0, every bank is closed with row 0, and `pwr_o` is awake (0).
- R2: When chip select is sampled high, the command is reported as DESELECT (0), it changes no state and it is never illegal. An undefined encoding is reported as NOP (1) and is never illegal. The undefined encodings are all strobes low with bank bits 2 or 3, and RAS, CAS and WE all high.
- R3: With chip select low, the strobes {RAS,CAS,WE} decode as 000 mode write, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read and 110 burst stop. `cmd_o` codes are: 2 mode write, 3 extended mode write, 4 refresh, 5 self-refresh entry, 6 precharge, 7 precharge-all, 8 activate, 9 write, 10 read and 11 burst stop. The bank bits select bank 0..3 as a binary value, with BA0 as bit 0. An accepted activate opens that bank and latches `addr_i[ROW_W-1:0]` as its row.
- R4: A precharge with A10 low closes only the addressed bank. With A10 high it closes every open bank and ignores the bank bits.
- R5: A bank closed at edge k may be activated at edge k+`TRP_CYC` or later. An activate to that bank at an earlier edge is illegal.
- R6: An activate to a bank that is open or still closing is illegal. A read or write to a bank that is not open is illegal. In both cases the bank state is left unchanged.
- R7: A read or write with A10 high (auto-precharge) closes its bank at the command edge, and the R5 window follows. With A10 low the bank stays open. `cmd_bank_o` and `cmd_ap_o` report the sampled bank bits and A10.
- R8: Bank bits 0 select the base mode write and bank bits 1 select the extended mode write. Either one is illegal unless all banks are idle, with no bank open and none still closing.
- R9: After an accepted mode write at edge k, any command other than NOP or DESELECT is illegal before edge k+`MRD_CYC`.
- R10: A refresh with CKE high is illegal unless all banks are idle.
- R11: CKE sampled low while awake enters active power-down (2) if any bank is open, and precharge power-down (1) otherwise. While powered down, on the entry edge and on the exit edge (CKE sampled high), commands are ignored and `cmd_o` reads NOP.
- R12: A refresh sampled with CKE low while awake is reported as self-refresh entry (5). It enters self refresh (3) when all banks are idle and no lockout is pending. Otherwise it is illegal and the R11 power-down choice applies.
- R13: `illegal_o` is high for exactly the cycle that reports the offending command. No bank opens or closes as a result of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Bank select bits (bit 0 = BA0) |
| addr_i | input | ADDR_W | Address bus; bit AP_BIT is A10 |
| cmd_o | output | 4 | Command acted on at the last edge |
| cmd_bank_o | output | 2 | Bank bits sampled at the last edge |
| cmd_ap_o | output | 1 | A10 sampled at the last edge |
| illegal_o | output | 1 | Last command was illegal in the current state |
| bank_open_o | output | 4 | Per-bank open flag |
| bank_row_o | output | 4 x ROW_W | Per-bank latched row |
| pwr_o | output | 2 | Power mode: 0 awake, 1 precharge PD, 2 active PD, 3 self refresh |

## Verification
The bound checker tests on every cycle that an illegal command or any powered-down cycle leaves the open flags untouched, and that the power mode agrees with the open flags. It also tests that an accepted activate, precharge-all or read/write leaves the target bank in the right state, and that a command right after a mode write is flagged. Several things appear only in the bench's sequences against its cycle-indexed reference model: the exact length of the precharge window, the rows latched per bank, the decode of every strobe pattern and the choice between self refresh and power-down.

// File: rtl/ddrtrk_pkg.sv
package ddrtrk_pkg;

    localparam int BA_W  = 2;
    localparam int NBANK = 1 << BA_W;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_MRS   = 4'd2,
        CMD_EMRS  = 4'd3,
        CMD_REF   = 4'd4,
        CMD_SREF  = 4'd5,
        CMD_PRE   = 4'd6,
        CMD_PREA  = 4'd7,
        CMD_ACT   = 4'd8,
        CMD_WR    = 4'd9,
        CMD_RD    = 4'd10,
        CMD_BST   = 4'd11
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_AWAKE  = 2'd0,
        PWR_PRE_PD = 2'd1,
        PWR_ACT_PD = 2'd2,
        PWR_SELF   = 2'd3
    } pwr_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_e;

    typedef struct packed {
        cmd_e            kind;
        logic [BA_W-1:0] bank;
        logic            ap;
    } dec_t;

    // Commands that never need a legality check and never act
    function automatic logic is_quiet(cmd_e k);
        return (k == CMD_NOP) || (k == CMD_DESEL);
    endfunction

    // Commands that require every bank to be idle
    function automatic logic needs_all_idle(cmd_e k);
        return (k == CMD_MRS) || (k == CMD_EMRS) || (k == CMD_REF);
    endfunction

endpackage

// File: rtl/ddrtrk_decode.sv
module ddrtrk_decode
    import ddrtrk_pkg::*;
(
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            ap,
    output dec_t            dec
);

    always_comb begin
        dec.bank = ba;
        dec.ap   = ap;
        if (cs_n) begin
            dec.kind = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: begin
                    if (ba == BA_W'(0))      dec.kind = CMD_MRS;
                    else if (ba == BA_W'(1)) dec.kind = CMD_EMRS;
                    else                     dec.kind = CMD_NOP;
                end
                3'b001:  dec.kind = CMD_REF;
                3'b010:  dec.kind = ap ? CMD_PREA : CMD_PRE;
                3'b011:  dec.kind = CMD_ACT;
                3'b100:  dec.kind = CMD_WR;
                3'b101:  dec.kind = CMD_RD;
                3'b110:  dec.kind = CMD_BST;
                default: dec.kind = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddrtrk_bank.sv
module ddrtrk_bank
    import ddrtrk_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int TRP_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output bank_e            st_o,
    output logic             idle_ok_o,
    output logic [ROW_W-1:0] row_o
);

    localparam int CNT_W = (TRP_CYC > 1) ? $clog2(TRP_CYC) : 1;

    bank_e            st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            unique case (st_q)
                BK_IDLE: begin
                    if (open_req) begin
                        st_q  <= BK_OPEN;
                        row_q <= row_in;
                    end
                end
                BK_OPEN: begin
                    if (close_req) begin
                        st_q  <= BK_CLOSING;
                        cnt_q <= CNT_W'(TRP_CYC - 1);
                    end
                end
                BK_CLOSING: begin
                    if (cnt_q == '0) begin
                        if (open_req) begin
                            st_q  <= BK_OPEN;
                            row_q <= row_in;
                        end else begin
                            st_q <= BK_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: st_q <= BK_IDLE;
            endcase
        end
    end

    // A closing bank whose window ends at this edge counts as idle
    assign idle_ok_o = (st_q == BK_IDLE) || ((st_q == BK_CLOSING) && (cnt_q == '0));
    assign st_o      = st_q;
    assign row_o     = row_q;

endmodule

// File: rtl/ddrtrk_power.sv
module ddrtrk_power
    import ddrtrk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic sref_req,
    input  logic sref_ok,
    input  logic any_open,
    output pwr_e pwr_o,
    output logic run_o
);

    pwr_e pwr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q <= PWR_AWAKE;
        end else if (pwr_q == PWR_AWAKE) begin
            if (!cke) begin
                if (sref_req && sref_ok) pwr_q <= PWR_SELF;
                else if (any_open)       pwr_q <= PWR_ACT_PD;
                else                     pwr_q <= PWR_PRE_PD;
            end
        end else if (cke) begin
            pwr_q <= PWR_AWAKE;
        end
    end

    assign pwr_o = pwr_q;
    assign run_o = (pwr_q == PWR_AWAKE) && cke;

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddrtrk_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int ROW_W   = 13,
    parameter int AP_BIT  = 10,
    parameter int TRP_CYC = 3,
    parameter int MRD_CYC = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cke_i,
    input  logic                        cs_n_i,
    input  logic                        ras_n_i,
    input  logic                        cas_n_i,
    input  logic                        we_n_i,
    input  logic [1:0]                  ba_i,
    input  logic [ADDR_W-1:0]           addr_i,
    output logic [3:0]                  cmd_o,
    output logic [1:0]                  cmd_bank_o,
    output logic                        cmd_ap_o,
    output logic                        illegal_o,
    output logic [3:0]                  bank_open_o,
    output logic [3:0][ROW_W-1:0]       bank_row_o,
    output logic [1:0]                  pwr_o
);

    localparam int LK_W = (MRD_CYC > 1) ? $clog2(MRD_CYC) : 1;

    dec_t             dec;
    pwr_e             pwr;
    logic             run;
    logic             awake;
    bank_e            bst   [NBANK];
    logic [NBANK-1:0] idle_ok;
    logic [NBANK-1:0] is_open;
    logic [NBANK-1:0] open_req;
    logic [NBANK-1:0] close_req;
    logic             all_idle;
    logic             any_open;
    logic             locked;
    logic             sref_req;
    logic             sref_ok;
    logic             ill_c;
    logic             accept;
    cmd_e             eff_kind;
    logic [LK_W-1:0]  lock_q;
    cmd_e             cmd_q;
    logic [BA_W-1:0]  bank_q;
    logic             ap_q;
    logic             ill_q;

    ddrtrk_decode u_dec (
        .cs_n  (cs_n_i),
        .ras_n (ras_n_i),
        .cas_n (cas_n_i),
        .we_n  (we_n_i),
        .ba    (ba_i),
        .ap    (addr_i[AP_BIT]),
        .dec   (dec)
    );

    assign all_idle = &idle_ok;
    assign any_open = |is_open;
    assign locked   = (lock_q != '0);
    assign sref_req = (dec.kind == CMD_REF);
    assign sref_ok  = all_idle && !locked;

    ddrtrk_power u_pwr (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke_i),
        .sref_req (sref_req),
        .sref_ok  (sref_ok),
        .any_open (any_open),
        .pwr_o    (pwr),
        .run_o    (run)
    );

    assign awake = (pwr == PWR_AWAKE);

    // Command that is reported and acted on at this edge
    always_comb begin
        if (!awake)      eff_kind = CMD_NOP;
        else if (!cke_i) eff_kind = sref_req ? CMD_SREF : CMD_NOP;
        else             eff_kind = dec.kind;
    end

    // Legality against lockout and bank state
    always_comb begin
        ill_c = 1'b0;
        if (run) begin
            if (locked && !is_quiet(dec.kind)) begin
                ill_c = 1'b1;
            end else if (needs_all_idle(dec.kind)) begin
                ill_c = !all_idle;
            end else if (dec.kind == CMD_ACT) begin
                ill_c = !idle_ok[dec.bank];
            end else if ((dec.kind == CMD_RD) || (dec.kind == CMD_WR)) begin
                ill_c = !is_open[dec.bank];
            end
        end else if (awake && !cke_i && sref_req) begin
            ill_c = !sref_ok;
        end
    end

    assign accept = run && !ill_c;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        logic rw;
        logic [ROW_W-1:0] row_w;

        assign hit = (dec.bank == BA_W'(b));
        assign rw  = (dec.kind == CMD_RD) || (dec.kind == CMD_WR);
        assign open_req[b]  = accept && (dec.kind == CMD_ACT) && hit;
        assign close_req[b] = accept && (((dec.kind == CMD_PRE) && hit) ||
                                         (dec.kind == CMD_PREA) ||
                                         (rw && dec.ap && hit));

        ddrtrk_bank #(
            .ROW_W   (ROW_W),
            .TRP_CYC (TRP_CYC)
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .open_req  (open_req[b]),
            .close_req (close_req[b]),
            .row_in    (addr_i[ROW_W-1:0]),
            .st_o      (bst[b]),
            .idle_ok_o (idle_ok[b]),
            .row_o     (row_w)
        );

        assign is_open[b]     = (bst[b] == BK_OPEN);
        assign bank_row_o[b]  = row_w;
        assign bank_open_o[b] = is_open[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
        end else if (accept && ((dec.kind == CMD_MRS) || (dec.kind == CMD_EMRS))) begin
            lock_q <= LK_W'(MRD_CYC - 1);
        end else if (locked) begin
            lock_q <= lock_q - LK_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            ap_q   <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            cmd_q  <= eff_kind;
            bank_q <= ba_i;
            ap_q   <= addr_i[AP_BIT];
            ill_q  <= ill_c;
        end
    end

    assign cmd_o      = cmd_q;
    assign cmd_bank_o = bank_q;
    assign cmd_ap_o   = ap_q;
    assign illegal_o  = ill_q;
    assign pwr_o      = pwr;

endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk
    import ddrtrk_pkg::*;
#(
    parameter int MRD_CYC = 2
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] cmd_o,
    input logic [1:0] cmd_bank_o,
    input logic       cmd_ap_o,
    input logic       illegal_o,
    input logic [3:0] bank_open_o,
    input logic [1:0] pwr_o
);

    // R13
    illegal_keeps_banks_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $stable(bank_open_o));

    // R11
    powerdown_freezes_banks_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_o != PWR_AWAKE) |-> $stable(bank_open_o));

    // R11
    active_pd_has_open_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_o == PWR_ACT_PD) |-> (bank_open_o != 4'd0));

    // R12
    idle_pd_all_closed_chk: assert property (@(posedge clk) disable iff (rst)
        ((pwr_o == PWR_PRE_PD) || (pwr_o == PWR_SELF)) |-> (bank_open_o == 4'd0));

    // R2
    deselect_never_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_DESEL) |-> !illegal_o);

    // R9
    mode_lockout_chk: assert property (@(posedge clk) disable iff (rst)
        ((MRD_CYC >= 2) &&
         (($past(cmd_o) == CMD_MRS) || ($past(cmd_o) == CMD_EMRS)) &&
         !$past(illegal_o) &&
         (cmd_o != CMD_NOP) && (cmd_o != CMD_DESEL)) |-> illegal_o);

    // R3
    activate_opens_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd_o == CMD_ACT) && !illegal_o) |-> bank_open_o[cmd_bank_o]);

    // R4
    precharge_all_closes_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd_o == CMD_PREA) && !illegal_o) |-> (bank_open_o == 4'd0));

    // R7
    auto_precharge_chk: assert property (@(posedge clk) disable iff (rst)
        (((cmd_o == CMD_RD) || (cmd_o == CMD_WR)) && !illegal_o) |->
            (bank_open_o[cmd_bank_o] == !cmd_ap_o));

endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
    .MRD_CYC (MRD_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_o       (cmd_o),
    .cmd_bank_o  (cmd_bank_o),
    .cmd_ap_o    (cmd_ap_o),
    .illegal_o   (illegal_o),
    .bank_open_o (bank_open_o),
    .pwr_o       (pwr_o)
);

// File: tb/ddr_cmd_tracker_tb.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_tb;

    localparam int TRP = 3;
    localparam int MRD = 2;

    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_BST = 4'b0110;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_DES = 4'b1010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke_i = 1'b1;
    logic        cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic [1:0]  ba_i = 2'd0;
    logic [12:0] addr_i = '0;
    logic [3:0]  cmd_o;
    logic [1:0]  cmd_bank_o;
    logic        cmd_ap_o;
    logic        illegal_o;
    logic [3:0]  bank_open_o;
    logic [3:0][12:0] bank_row_o;
    logic [1:0]  pwr_o;

    ddr_cmd_tracker #(
        .ADDR_W (13), .ROW_W (13), .AP_BIT (10), .TRP_CYC (TRP), .MRD_CYC (MRD)
    ) u_dut (
        .clk (clk), .rst (rst), .cke_i (cke_i), .cs_n_i (cs_n_i),
        .ras_n_i (ras_n_i), .cas_n_i (cas_n_i), .we_n_i (we_n_i),
        .ba_i (ba_i), .addr_i (addr_i), .cmd_o (cmd_o),
        .cmd_bank_o (cmd_bank_o), .cmd_ap_o (cmd_ap_o), .illegal_o (illegal_o),
        .bank_open_o (bank_open_o), .bank_row_o (bank_row_o), .pwr_o (pwr_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state, indexed by edge number
    int          cyc = 0;
    bit          m_open [4];
    logic [12:0] m_row  [4];
    int          m_free [4];
    int          m_lock = 0;
    int          m_pwr  = 0;
    int          e_cmd, e_ill;

    task automatic check_val(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int decode_kind(input logic [3:0] c, input logic [1:0] ba, input logic a10);
        if (c[3]) return 0;
        case (c[2:0])
            3'b000:  return (ba == 2'd0) ? 2 : (ba == 2'd1) ? 3 : 1;
            3'b001:  return 4;
            3'b010:  return a10 ? 7 : 6;
            3'b011:  return 8;
            3'b100:  return 9;
            3'b101:  return 10;
            3'b110:  return 11;
            default: return 1;
        endcase
    endfunction

    task automatic m_close(input int b);
        if (m_open[b]) begin
            m_open[b] = 0;
            m_free[b] = cyc + TRP;
        end
    endtask

    task automatic model(input logic [3:0] c, input logic ck, input logic [1:0] ba, input logic [12:0] a);
        int  kind;
        bit  all_idle, any_open, locked, ill;
        kind = decode_kind(c, ba, a[10]);
        all_idle = 1; any_open = 0;
        for (int b = 0; b < 4; b++) begin
            if (m_open[b]) any_open = 1;
            if (m_open[b] || cyc < m_free[b]) all_idle = 0;
        end
        locked = cyc < m_lock;
        ill = 0;
        if (m_pwr != 0) begin
            e_cmd = 1;
            if (ck) m_pwr = 0;
        end else if (!ck) begin
            if (kind == 4) begin
                e_cmd = 5;
                if (all_idle && !locked) m_pwr = 3;
                else begin ill = 1; m_pwr = any_open ? 2 : 1; end
            end else begin
                e_cmd = 1;
                m_pwr = any_open ? 2 : 1;
            end
        end else begin
            e_cmd = kind;
            if (locked && kind != 0 && kind != 1) ill = 1;
            else case (kind)
                2, 3, 4: ill = !all_idle;
                8:       ill = m_open[ba] || (cyc < m_free[ba]);
                9, 10:   ill = !m_open[ba];
                default: ill = 0;
            endcase
            if (!ill) case (kind)
                2, 3: m_lock = cyc + MRD;
                6:    m_close(ba);
                7:    for (int b = 0; b < 4; b++) m_close(b);
                8:    begin m_open[ba] = 1; m_row[ba] = a; end
                9, 10: if (a[10]) m_close(ba);
                default: ;
            endcase
        end
        e_ill = ill;
    endtask

    task automatic step(input logic [3:0] c, input logic ck, input logic [1:0] ba,
                        input logic [12:0] a, input string req);
        logic [3:0] exp_open;
        @(negedge clk);
        cs_n_i = c[3]; ras_n_i = c[2]; cas_n_i = c[1]; we_n_i = c[0];
        cke_i = ck; ba_i = ba; addr_i = a;
        model(c, ck, ba, a);
        @(posedge clk);
        #1;
        for (int b = 0; b < 4; b++) exp_open[b] = m_open[b];
        check_val(req, "cmd", int'(cmd_o), e_cmd);
        check_val(req, "illegal", int'(illegal_o), e_ill);
        check_val(req, "pwr", int'(pwr_o), m_pwr);
        check_val(req, "open", int'(bank_open_o), int'(exp_open));
        check_val(req, "bank", int'(cmd_bank_o), int'(ba));
        check_val(req, "ap", int'(cmd_ap_o), int'(a[10]));
        for (int b = 0; b < 4; b++) check_val(req, "row", int'(bank_row_o[b]), int'(m_row[b]));
        cyc++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = '0; m_free[b] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check_val("R1", "cmd", int'(cmd_o), 1);
        check_val("R1", "illegal", int'(illegal_o), 0);
        check_val("R1", "open", int'(bank_open_o), 0);
        check_val("R1", "pwr", int'(pwr_o), 0);

        step(C_DES,   1, 2'd3, 13'h1fff, "R2");
        step(4'b1001, 1, 2'd1, 13'h0400, "R2");
        step(C_MRS,   1, 2'd2, 13'h0000, "R2");
        step(C_NOP,   1, 2'd0, 13'h0000, "R2");
        step(C_ACT,   1, 2'd1, 13'h01ab, "R3");
        step(C_ACT,   1, 2'd2, 13'h1234, "R3");
        step(C_ACT,   1, 2'd1, 13'h0fff, "R6");
        step(C_RD,    1, 2'd3, 13'h0000, "R6");
        step(C_RD,    1, 2'd1, 13'h0000, "R7");
        step(C_WR,    1, 2'd2, 13'h0400, "R7");
        step(C_ACT,   1, 2'd2, 13'h0055, "R5");
        step(C_NOP,   1, 2'd0, 13'h0000, "R5");
        step(C_ACT,   1, 2'd2, 13'h0077, "R5");
        step(C_PRE,   1, 2'd1, 13'h0000, "R4");
        step(C_REF,   1, 2'd0, 13'h0000, "R10");
        step(C_PRE,   1, 2'd0, 13'h0400, "R4");
        step(C_REF,   1, 2'd0, 13'h0000, "R10");
        step(C_NOP,   1, 2'd0, 13'h0000, "R5");
        step(C_NOP,   1, 2'd0, 13'h0000, "R5");
        step(C_REF,   1, 2'd0, 13'h0000, "R10");
        step(C_MRS,   1, 2'd0, 13'h0031, "R8");
        step(C_BST,   1, 2'd0, 13'h0000, "R9");
        step(C_MRS,   1, 2'd1, 13'h0002, "R8");
        step(C_NOP,   1, 2'd0, 13'h0000, "R9");
        step(C_ACT,   1, 2'd3, 13'h0abc, "R9");
        step(C_MRS,   1, 2'd0, 13'h0000, "R8");
        step(C_NOP,   0, 2'd0, 13'h0000, "R11");
        step(C_RD,    0, 2'd3, 13'h0000, "R11");
        step(C_PRE,   0, 2'd3, 13'h0400, "R11");
        step(C_NOP,   1, 2'd0, 13'h0000, "R11");
        step(C_REF,   0, 2'd0, 13'h0000, "R12");
        step(C_NOP,   1, 2'd0, 13'h0000, "R12");
        step(C_PRE,   1, 2'd3, 13'h0000, "R4");
        step(C_NOP,   0, 2'd0, 13'h0000, "R11");
        step(C_NOP,   1, 2'd0, 13'h0000, "R11");
        step(C_NOP,   1, 2'd0, 13'h0000, "R11");
        step(C_REF,   0, 2'd0, 13'h0000, "R12");
        step(C_NOP,   0, 2'd0, 13'h0000, "R12");
        step(C_NOP,   1, 2'd0, 13'h0000, "R12");
        step(C_MRS,   1, 2'd0, 13'h0000, "R9");
        step(C_REF,   0, 2'd0, 13'h0000, "R12");
        step(C_NOP,   1, 2'd0, 13'h0000, "R12");

        // Constrained random traffic with a fixed seed
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  c;
            logic        ck;
            logic [12:0] a;
            logic [1:0]  ba;
            int          r;
            r  = int'($urandom % 16);
            ba = 2'($urandom);
            a  = 13'($urandom);
            case (r)
                0, 1, 2, 3: c = C_ACT;
                4, 5:       c = C_RD;
                6, 7:       c = C_WR;
                8, 9:       c = C_PRE;
                10:         c = C_REF;
                11:         c = C_MRS;
                12:         c = C_BST;
                14:         c = {1'b1, 3'($urandom)};
                default:    c = C_NOP;
            endcase
            if (m_pwr != 0) ck = 1'($urandom);
            else            ck = (($urandom % 16) != 0);
            step(c, ck, ba, a, "R13");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule